// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block sits on the device side of a DDR2-style SDRAM command path. It takes decoded READ and WRITE column commands and holds each for a programmable additive latency (AL) before releasing it as an internal column command. A controller can then send the column command early, before the row-to-column delay has run out, as long as AL is no larger than that delay in cycles.

The block also marks the data windows. The read window opens AL + CL cycles after the external command and the write window opens one cycle earlier. AL comes from a 3-bit field in the extended mode register, loaded through mode-register writes. CL comes from a configuration input. Both values are captured when a command is accepted, so a later change never moves a command already in flight. Illegal settings raise a sticky error flag.

Top module: `postedColSched`

## Requirements
- R1: After reset, AL is 0, `issueValid`, `rdValid`, `wrCapture` and `cfgError` are all low.
- R2: A mode-register load with select 2'b01 and a code of 0 to 4 in data bits [5:3] sets AL for commands accepted from the next cycle on.
- R3: A command accepted in cycle t appears on `issueValid` with the same type, bank and column in cycle t+AL. With AL = 0 it appears in cycle t itself.
- R4: An accepted READ produces a one-cycle `rdValid` pulse in cycle t+AL+CL.
- R5: An accepted WRITE produces a one-cycle `wrCapture` pulse in cycle t+AL+CL-1.
- R6: Commands accepted on consecutive cycles each come out AL cycles later, in their original order.
- R7: AL and CL are captured at acceptance. A later AL load or CL change does not shift a pending command or its data window.
- R8: A select-2'b01 load with a code of 5, 6 or 7 in bits [5:3] sets `cfgError` and leaves the previous AL in force.
- R9: A select-2'b10 load with any bit other than bit 7 set sets `cfgError`. A load with only bit 7 set does not. Loads with select 2'b00 or 2'b11 leave AL and `cfgError` unchanged.
- R10: If a shortened AL makes a new command due in the same cycle as an older pending one, the older command is issued, the new one is dropped with no data window, and `cfgError` is set.
- R11: A command accepted while `casLat` is outside 3..6 is still issued after AL, produces no data pulse, and sets `cfgError`.
- R12: `cfgError` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Column command strobe |
| cmdIsWrite | input | 1 | 1 = WRITE, 0 = READ |
| cmdBank | input | BANK_W | Bank address of the command |
| cmdCol | input | COL_W | Column address of the command |
| mrsValid | input | 1 | Mode-register load strobe |
| mrsSel | input | 2 | Target register select: 00, 01 (holds AL), 10 (only bit 7 writable), 11 |
| mrsData | input | MRS_W | Mode-register load value |
| casLat | input | CL_W | Configured CAS latency in cycles |
| issueValid | output | 1 | Internal column command strobe |
| issueIsWrite | output | 1 | Type of the issued command |
| issueBank | output | BANK_W | Bank of the issued command |
| issueCol | output | COL_W | Column of the issued command |
| rdValid | output | 1 | First read data beat is due this cycle |
| wrCapture | output | 1 | First write data beat is to be captured this cycle |
| cfgError | output | 1 | Sticky illegal-setting flag |

## Verification
A wrong delay-slot index or AL register shows up as `issueValid` one or more cycles away from t+AL, within at most four cycles of the command. A wrong shift position in the data timing shows up as a misplaced `rdValid` or `wrCapture` pulse no later than ten cycles after acceptance. Settings that are sampled late only show when AL or CL changes while a command is in flight, so those cases are driven on purpose. A lost update of the error register is visible on `cfgError` in the cycle after the offending load or command.

// File: rtl/postedColPkg.sv
package postedColPkg;
  parameter int BANK_W = 2;
  parameter int COL_W  = 10;
  parameter int AL_W   = 3;
  parameter int CL_W   = 3;
  parameter int MRS_W  = 14;

  // position of the latency field and of the one writable bit of the select-10 register
  localparam int AL_LSB     = 3;
  localparam int HITEMP_BIT = 7;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'b00,
    SEL_EXT1  = 2'b01,
    SEL_EXT2  = 2'b10,
    SEL_EXT3  = 2'b11
  } mrSel_e;

  typedef struct packed {
    logic              valid;
    logic              isWrite;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } colCmd_t;

  typedef struct packed {
    logic            push;
    logic [AL_W-1:0] delay;
    logic [CL_W-1:0] cl;
    logic            dataEn;
  } ctlStrobe_t;
endpackage

// File: rtl/alCtl.sv
module alCtl import postedColPkg::*; #(
  parameter int MAX_AL = 4,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             mrsValid,
  input  logic [1:0]       mrsSel,
  input  logic [MRS_W-1:0] mrsData,
  input  logic [CL_W-1:0]  casLat,
  input  logic             slotClash,
  output ctlStrobe_t       strobe,
  output logic             cfgError
);
  localparam logic [MRS_W-1:0] EXT2_OK = MRS_W'(1) << HITEMP_BIT;

  logic [AL_W-1:0] alReg;
  logic [AL_W-1:0] alCode;
  logic            alBad;
  logic            ext2Bad;
  logic            clOk;
  logic            loadAl;
  logic            mrsErr;
  logic            cmdErr;
  mrSel_e          sel;

  always_comb begin
    sel     = mrSel_e'(mrsSel);
    alCode  = mrsData[AL_LSB +: AL_W];
    alBad   = int'(alCode) > MAX_AL;
    ext2Bad = (mrsData & ~EXT2_OK) != '0;
    clOk    = (int'(casLat) >= MIN_CL) && (int'(casLat) <= MAX_CL);
    loadAl  = mrsValid && (sel == SEL_EXT1) && !alBad;
    mrsErr  = mrsValid && (((sel == SEL_EXT1) && alBad) ||
                           ((sel == SEL_EXT2) && ext2Bad));
    cmdErr  = cmdValid && !clOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alReg    <= '0;
      cfgError <= 1'b0;
    end else begin
      if (loadAl) alReg <= alCode;
      if (mrsErr || cmdErr || slotClash) cfgError <= 1'b1;
    end
  end

  assign strobe = '{push: cmdValid, delay: alReg, cl: casLat, dataEn: clOk};
endmodule

// File: rtl/alPipe.sv
module alPipe import postedColPkg::*; #(
  parameter int MAX_AL = 4,
  parameter int MAX_CL = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  colCmd_t    cmdIn,
  output colCmd_t    issue,
  output logic       rdValid,
  output logic       wrCapture,
  output logic       slotClash
);
  localparam int SLOTS = (MAX_AL > 1) ? MAX_AL : 2;
  localparam int SL_W  = $clog2(SLOTS);
  localparam int SPAN  = MAX_AL + MAX_CL;
  localparam int IX_W  = $clog2(SPAN);

  colCmd_t          slot    [SLOTS];
  colCmd_t          slotNxt [SLOTS];
  logic [SPAN-1:0]  rdSh, wrSh, rdNxt, wrNxt;
  logic [SL_W-1:0]  slotIx;
  logic [IX_W-1:0]  rdIx, wrIx;
  logic             pushNow;

  always_comb begin
    slotClash = 1'b0;
    for (int i = 0; i < SLOTS - 1; i++) slotNxt[i] = slot[i + 1];
    slotNxt[SLOTS-1] = '0;
    issue  = slot[0];
    slotIx = SL_W'(strobe.delay - 1'b1);
    if (strobe.push) begin
      if (strobe.delay == '0) begin
        if (slot[0].valid) slotClash = 1'b1;
        else               issue     = cmdIn;
      end else if (slotNxt[slotIx].valid) begin
        slotClash = 1'b1;
      end else begin
        slotNxt[slotIx] = cmdIn;
      end
    end
    pushNow = strobe.push && !slotClash;

    rdNxt = rdSh >> 1;
    wrNxt = wrSh >> 1;
    rdIx  = IX_W'(int'(strobe.delay) + int'(strobe.cl) - 1);
    wrIx  = IX_W'(int'(strobe.delay) + int'(strobe.cl) - 2);
    if (pushNow && strobe.dataEn) begin
      if (cmdIn.isWrite) wrNxt[wrIx] = 1'b1;
      else               rdNxt[rdIx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
      rdSh <= '0;
      wrSh <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= slotNxt[i];
      rdSh <= rdNxt;
      wrSh <= wrNxt;
    end
  end

  assign rdValid   = rdSh[0];
  assign wrCapture = wrSh[0];
endmodule

// File: rtl/postedColSched.sv
module postedColSched import postedColPkg::*; #(
  parameter int MAX_AL = 4,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              mrsValid,
  input  logic [1:0]        mrsSel,
  input  logic [MRS_W-1:0]  mrsData,
  input  logic [CL_W-1:0]   casLat,
  output logic              issueValid,
  output logic              issueIsWrite,
  output logic [BANK_W-1:0] issueBank,
  output logic [COL_W-1:0]  issueCol,
  output logic              rdValid,
  output logic              wrCapture,
  output logic              cfgError
);
  ctlStrobe_t strobe;
  colCmd_t    cmdIn;
  colCmd_t    issue;
  logic       slotClash;

  assign cmdIn = '{valid: cmdValid, isWrite: cmdIsWrite, bank: cmdBank, col: cmdCol};

  alCtl #(.MAX_AL(MAX_AL), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)) ctl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .mrsValid(mrsValid),
    .mrsSel(mrsSel), .mrsData(mrsData), .casLat(casLat),
    .slotClash(slotClash), .strobe(strobe), .cfgError(cfgError)
  );

  alPipe #(.MAX_AL(MAX_AL), .MAX_CL(MAX_CL)) pipe_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdIn(cmdIn), .issue(issue),
    .rdValid(rdValid), .wrCapture(wrCapture), .slotClash(slotClash)
  );

  assign issueValid   = issue.valid;
  assign issueIsWrite = issue.isWrite;
  assign issueBank    = issue.bank;
  assign issueCol     = issue.col;
endmodule

// File: rtl/postedColSched_chk.sv
module postedColSched_chk import postedColPkg::*; #(
  parameter int MAX_AL = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdIsWrite,
  input logic [COL_W-1:0] cmdCol,
  input logic [CL_W-1:0]  casLat,
  input logic             mrsValid,
  input logic [1:0]       mrsSel,
  input logic [MRS_W-1:0] mrsData,
  input logic             issueValid,
  input logic [COL_W-1:0] issueCol,
  input logic             rdValid,
  input logic             cfgError,
  input logic [AL_W-1:0]  alCur,
  input logic             slotClash
);
  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R8
  bad_al_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsSel == 2'b01 && int'(mrsData[AL_LSB +: AL_W]) > MAX_AL) |=> cfgError);

  // R9
  ext2_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsSel == 2'b10 && (mrsData & ~(MRS_W'(1) << HITEMP_BIT)) != '0) |=> cfgError);

  // R3
  zero_al_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && alCur == '0 && !slotClash) |-> (issueValid && issueCol == cmdCol));

  // R3
  one_al_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && alCur == AL_W'(1) && !slotClash) |=> (issueValid && issueCol == $past(cmdCol)));

  // R4
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdIsWrite && alCur == '0 && casLat == CL_W'(3) && !slotClash) |-> ##3 rdValid);
endmodule

bind postedColSched postedColSched_chk #(.MAX_AL(MAX_AL)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
  .cmdCol(cmdCol), .casLat(casLat), .mrsValid(mrsValid), .mrsSel(mrsSel),
  .mrsData(mrsData), .issueValid(issueValid), .issueCol(issueCol),
  .rdValid(rdValid), .cfgError(cfgError), .alCur(strobe.delay),
  .slotClash(slotClash)
);

// File: tb/postedColSched_tb_top.sv
module postedColSched_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdIsWrite = 1'b0;
  logic [1:0]  cmdBank = '0;
  logic [9:0]  cmdCol = '0;
  logic        mrsValid = 1'b0;
  logic [1:0]  mrsSel = '0;
  logic [13:0] mrsData = '0;
  logic [2:0]  casLat = 3'd3;
  logic        issueValid, issueIsWrite, rdValid, wrCapture, cfgError;
  logic [1:0]  issueBank;
  logic [9:0]  issueCol;

  postedColSched dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .mrsValid(mrsValid), .mrsSel(mrsSel),
    .mrsData(mrsData), .casLat(casLat), .issueValid(issueValid),
    .issueIsWrite(issueIsWrite), .issueBank(issueBank), .issueCol(issueCol),
    .rdValid(rdValid), .wrCapture(wrCapture), .cfgError(cfgError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         cyc;
    logic       wr;
    logic [1:0] bank;
    logic [9:0] col;
    string      tag;
  } expIssue_t;

  typedef struct {
    int    cyc;
    string tag;
  } expPulse_t;

  expIssue_t issueQ[$];
  expPulse_t rdQ[$];
  expPulse_t wrQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int expAl = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    mrsValid = 1'b0;
  endtask

  task automatic checkVal(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic sendCmd(logic wr, int col, bit drop, string issueTag, string dataTag);
    expIssue_t e;
    expPulse_t d;
    cmdValid   = 1'b1;
    cmdIsWrite = wr;
    cmdBank    = 2'(col);
    cmdCol     = 10'(col);
    if (!drop) begin
      e.cyc = cyc + expAl; e.wr = wr; e.bank = 2'(col); e.col = 10'(col); e.tag = issueTag;
      issueQ.push_back(e);
      if (int'(casLat) >= 3 && int'(casLat) <= 6) begin
        d.cyc = cyc + expAl + int'(casLat) - (wr ? 1 : 0);
        d.tag = dataTag;
        if (wr) wrQ.push_back(d);
        else    rdQ.push_back(d);
      end
    end
    tick();
  endtask

  task automatic setMode(logic [1:0] sel, logic [13:0] data);
    mrsValid = 1'b1;
    mrsSel   = sel;
    mrsData  = data;
    if (sel == 2'b01 && int'(data[5:3]) <= 4) expAl = int'(data[5:3]);
    tick();
  endtask

  task automatic drain(string tag);
    repeat (14) tick();
    nChecks++;
    if (issueQ.size() != 0 || rdQ.size() != 0 || wrQ.size() != 0) begin
      nFails++;
      $display("FAIL %s pending: actual=%0d/%0d/%0d expected=0/0/0", tag,
               issueQ.size(), rdQ.size(), wrQ.size());
      issueQ.delete(); rdQ.delete(); wrQ.delete();
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    tick();
    tick();
    checkVal("R1", "issueValid in reset", issueValid, 1'b0);
    checkVal("R1", "rdValid in reset", rdValid, 1'b0);
    checkVal("R1", "wrCapture in reset", wrCapture, 1'b0);
    checkVal("R1", "cfgError in reset", cfgError, 1'b0);
    rstN = 1'b1;
    expAl = 0;
    tick();
  endtask

  // scoreboard monitor: compares outputs with the expected items for this cycle
  always @(negedge clk) begin : monitor
    int hit;
    if (rstN && !done) begin
      hit = -1;
      foreach (issueQ[i]) if (hit < 0 && issueQ[i].cyc == cyc) hit = i;
      if (hit >= 0) begin
        nChecks++;
        if (!issueValid || issueIsWrite !== issueQ[hit].wr ||
            issueBank !== issueQ[hit].bank || issueCol !== issueQ[hit].col) begin
          nFails++;
          $display("FAIL %s issue @%0d: actual v=%0b w=%0b b=%0d c=%0h expected v=1 w=%0b b=%0d c=%0h",
                   issueQ[hit].tag, cyc, issueValid, issueIsWrite, issueBank, issueCol,
                   issueQ[hit].wr, issueQ[hit].bank, issueQ[hit].col);
        end
        issueQ.delete(hit);
      end else if (issueValid) begin
        nChecks++; nFails++;
        $display("FAIL R3 issue @%0d: actual=1 expected=0", cyc);
      end

      hit = -1;
      foreach (rdQ[i]) if (hit < 0 && rdQ[i].cyc == cyc) hit = i;
      if (hit >= 0) begin
        nChecks++;
        if (!rdValid) begin
          nFails++;
          $display("FAIL %s rdValid @%0d: actual=0 expected=1", rdQ[hit].tag, cyc);
        end
        rdQ.delete(hit);
      end else if (rdValid) begin
        nChecks++; nFails++;
        $display("FAIL R4 rdValid @%0d: actual=1 expected=0", cyc);
      end

      hit = -1;
      foreach (wrQ[i]) if (hit < 0 && wrQ[i].cyc == cyc) hit = i;
      if (hit >= 0) begin
        nChecks++;
        if (!wrCapture) begin
          nFails++;
          $display("FAIL %s wrCapture @%0d: actual=0 expected=1", wrQ[hit].tag, cyc);
        end
        wrQ.delete(hit);
      end else if (wrCapture) begin
        nChecks++; nFails++;
        $display("FAIL R5 wrCapture @%0d: actual=1 expected=0", cyc);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin : stimulus
    resetDut();

    // R2 R3 R4 R5: every AL 0..4 against CL 3..5
    for (int al = 0; al <= 4; al++) begin
      setMode(2'b01, 14'(al << 3));
      for (int cl = 3; cl <= 5; cl++) begin
        casLat = 3'(cl);
        sendCmd(1'b0, 16 * al + cl, 1'b0, "R2/R3", "R4");
        tick();
        sendCmd(1'b1, 16 * al + cl + 8, 1'b0, "R2/R3", "R5");
        drain("R3");
      end
    end
    checkVal("R2", "cfgError after legal loads", cfgError, 1'b0);

    // R6: back-to-back commands
    setMode(2'b01, 14'(3 << 3));
    casLat = 3'd4;
    for (int k = 0; k < 6; k++) sendCmd(1'(k), 100 + k, 1'b0, "R6", "R6");
    drain("R6");

    // R7: settings captured at acceptance
    setMode(2'b01, 14'(4 << 3));
    casLat = 3'd5;
    sendCmd(1'b0, 200, 1'b0, "R7", "R7");
    casLat = 3'd3;
    setMode(2'b01, 14'(1 << 3));
    sendCmd(1'b0, 201, 1'b0, "R7", "R7");
    drain("R7");

    // R9: other register loads
    setMode(2'b10, 14'h0080);
    setMode(2'b00, 14'(3 << 3));
    setMode(2'b11, 14'(2 << 3));
    checkVal("R9", "cfgError after bit-7-only load", cfgError, 1'b0);
    sendCmd(1'b1, 300, 1'b0, "R9", "R9");
    drain("R9");
    setMode(2'b10, 14'h0004);
    checkVal("R9", "cfgError after reserved-bit load", cfgError, 1'b1);
    repeat (5) tick();
    checkVal("R12", "cfgError held", cfgError, 1'b1);

    // R1: reset clears error and AL
    resetDut();
    checkVal("R12", "cfgError cleared by reset", cfgError, 1'b0);
    casLat = 3'd3;
    sendCmd(1'b0, 400, 1'b0, "R1", "R1");
    drain("R1");

    // R8: reserved AL codes
    setMode(2'b01, 14'(2 << 3));
    for (int code = 5; code <= 7; code++) setMode(2'b01, 14'(code << 3));
    checkVal("R8", "cfgError after reserved code", cfgError, 1'b1);
    sendCmd(1'b1, 500, 1'b0, "R8", "R8");
    drain("R8");

    // R10: shortened AL collides with an older pending command
    resetDut();
    setMode(2'b01, 14'(4 << 3));
    casLat = 3'd3;
    sendCmd(1'b0, 600, 1'b0, "R10", "R10");
    setMode(2'b01, 14'(1 << 3));
    tick();
    sendCmd(1'b1, 601, 1'b1, "R10", "R10");
    checkVal("R10", "cfgError on collision", cfgError, 1'b1);
    drain("R10");

    // R11: CL out of range
    resetDut();
    casLat = 3'd2;
    sendCmd(1'b0, 700, 1'b0, "R11", "R11");
    checkVal("R11", "cfgError on CL=2", cfgError, 1'b1);
    casLat = 3'd7;
    sendCmd(1'b1, 701, 1'b0, "R11", "R11");
    drain("R11");

    done = 1;
    finishRun();
  end
endmodule